// File: doc/BRIEF.md
# System Clock Speed-Mode Controller

This block keeps the control bits that choose where the internal CPU clock comes from and how far it is divided. It also guards the moves between three operating speeds. High speed takes the main oscillator divided by two, middle speed takes the main oscillator divided by eight, and low speed takes the sub oscillator divided by two. With an 8 MHz main and a 32 kHz sub oscillator, these give 4 MHz, 1 MHz and 16 kHz. All timing is derived from one fast reference clock. The two oscillators appear as single-cycle tick enables, and the internal clock leaves the block as a single-cycle strobe, `phi_en`. No clock is gated.

Software writes a speed field together with two oscillator bits. The write takes effect only when the transition it asks for is on an allowed arc. Any other write changes nothing and sets a sticky error flag. A separate start pulse loads a programmable wait. When the wait has run out, the block moves itself into middle speed. The register write port and the start pulse are plain control pins and have no valid/ready handshake: a write is either taken or refused in the cycle it is presented, and it cannot stall.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the block is in middle speed (`mode` = 01), with `main_en` = 1, `sub_en` = 0, `err` = 0 and `auto_busy` = 0.
- R2: The speed field encodes 00 = high, 01 = middle, 10 = low. `phi_en` pulses once every 2 enabled main ticks in high speed, once every 8 in middle speed, and once every 2 enabled sub ticks in low speed.
- R3: Writes that move between high and middle speed are accepted whether the sub oscillator runs or not.
- R4: Low speed is entered only if the sub oscillator is already running and the write keeps `wr_sub_run` = 1. While in low speed, a write that clears the sub bit is refused.
- R5: `wr_main_stop` = 1 is accepted only when the current mode is low and the write keeps low speed. Outside low speed the main oscillator always runs.
- R6: Leaving low speed is accepted only if the main oscillator is already running and `main_stable` = 1 during the write.
- R7: The reserved speed code 11 is always refused.
- R8: A refused write leaves mode and both oscillator bits unchanged and sets `err`. `err` stays set until reset.
- R9: `auto_start` is accepted when no wait is pending, the main oscillator runs and, if the block is in low speed, `main_stable` = 1. On acceptance, `auto_busy` rises and `auto_wait` is loaded. Each enabled main tick counts it down. One cycle after it reaches zero, the mode becomes 01 and `auto_busy` falls. A refused start sets `err`. Writes made while `auto_busy` = 1 are refused.
- R10: `phi_en` moves to a new source only on a pulse of the new divider. Switching between high and middle speed never leaves two strobes closer together than two main-tick periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_speed | input | 2 | Requested speed code |
| wr_main_stop | input | 1 | Requested main oscillator stop (1 = stop) |
| wr_sub_run | input | 1 | Requested sub oscillator run (1 = run) |
| auto_start | input | 1 | Start the timed switch into middle speed |
| auto_wait | input | WAIT_W | Main ticks to wait before the automatic switch |
| main_tick | input | 1 | One pulse per main oscillator period |
| sub_tick | input | 1 | One pulse per sub oscillator period |
| main_stable | input | 1 | Main oscillator has settled |
| mode | output | 2 | Current speed code |
| main_en | output | 1 | Main oscillator enable |
| sub_en | output | 1 | Sub oscillator enable |
| phi_en | output | 1 | Internal clock strobe |
| err | output | 1 | Sticky refused-request flag |
| auto_busy | output | 1 | Automatic switch wait in progress |

## Verification
Several properties are checked on every cycle by assertions: the reserved code never appears as the mode, low speed never runs without the sub oscillator, a stopped main oscillator is only seen in low speed, low speed is left only when the main oscillator was running, `err` never clears, and the end of the automatic wait always lands in middle speed. Other behaviours can only be shown by the bench's scenarios: the strobe rate of each mode, the spacing of strobes across a high/middle change, and the exact moment the timed switch fires. The bench also walks a fixed chain of accepted and refused writes to show which arcs exist.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    SPD_HIGH = 2'b00,
    SPD_MID  = 2'b01,
    SPD_LOW  = 2'b10,
    SPD_RSV  = 2'b11
  } speed_e;
endpackage

// File: rtl/clk_mode_regs.sv
module clk_mode_regs
  import clk_mode_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_speed,
  input  logic              wr_main_stop,
  input  logic              wr_sub_run,
  input  logic              auto_start,
  input  logic [WAIT_W-1:0] auto_wait,
  input  logic              main_tick,
  input  logic              main_stable,
  output speed_e            speed_o,
  output logic              main_stop_o,
  output logic              sub_run_o,
  output logic              err_o,
  output logic              busy_o
);
  speed_e            speed_q;
  logic              stop_q, run_q, err_q, busy_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              wr_ok, auto_ok;
  speed_e            req;

  assign req = speed_e'(wr_speed);

  // Arc check: a request is judged against the state held right now
  always_comb begin
    wr_ok = !busy_q && !auto_start && (req != SPD_RSV);
    if (req == SPD_LOW && !(run_q && wr_sub_run)) wr_ok = 1'b0;
    if (wr_main_stop && !(speed_q == SPD_LOW && req == SPD_LOW)) wr_ok = 1'b0;
    if (speed_q == SPD_LOW && req != SPD_LOW && (stop_q || !main_stable)) wr_ok = 1'b0;
  end

  assign auto_ok = !busy_q && !stop_q && (speed_q != SPD_LOW || main_stable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_q <= SPD_MID;
      stop_q  <= 1'b0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (busy_q) begin
        if (cnt_q == '0) begin
          speed_q <= SPD_MID;
          busy_q  <= 1'b0;
        end else if (main_tick && !stop_q) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (auto_start) begin
        if (auto_ok) begin
          busy_q <= 1'b1;
          cnt_q  <= auto_wait;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (wr_en) begin
        if (wr_ok) begin
          speed_q <= req;
          stop_q  <= wr_main_stop;
          run_q   <= wr_sub_run;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign speed_o     = speed_q;
  assign main_stop_o = stop_q;
  assign sub_run_o   = run_q;
  assign err_o       = err_q;
  assign busy_o      = busy_q;

  p_no_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    speed_q != SPD_RSV);
  p_low_has_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_q == SPD_LOW) |-> run_q);
  p_stop_only_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (speed_q == SPD_LOW));
  p_leave_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_q == SPD_LOW) |=> (speed_q == SPD_LOW || !$past(stop_q)));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_auto_lands_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (busy_q || speed_q == SPD_MID));
endmodule

// File: rtl/clk_mode_phi.sv
module clk_mode_phi
  import clk_mode_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 8,
  parameter int SUB_DIV  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_e speed,
  input  logic   main_tick,
  input  logic   sub_tick,
  input  logic   main_run,
  input  logic   sub_run,
  output logic   phi_en
);
  localparam int MW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int SW = (SUB_DIV > 2) ? $clog2(SUB_DIV) : 1;
  localparam logic [MW-1:0] M_LAST = MW'(SLOW_DIV - 1);
  localparam logic [MW-1:0] F_DIV  = MW'(FAST_DIV);
  localparam logic [MW-1:0] F_LAST = MW'(FAST_DIV - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SUB_DIV - 1);

  logic [MW-1:0] m_cnt;
  logic [SW-1:0] s_cnt;
  logic          m_adv, s_adv;
  logic [2:0]    pulse;     // index: 0 high, 1 middle, 2 low
  speed_e        sel_q;
  logic          phi_q, pulse_new, pulse_old;

  assign m_adv = main_tick && main_run;
  assign s_adv = sub_tick && sub_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0;
      s_cnt <= '0;
    end else begin
      if (m_adv) m_cnt <= (m_cnt == M_LAST) ? '0 : m_cnt + 1'b1;
      if (s_adv) s_cnt <= (s_cnt == S_LAST) ? '0 : s_cnt + 1'b1;
    end
  end

  // Fast boundaries nest inside slow ones since SLOW_DIV is a multiple of FAST_DIV
  assign pulse[0] = m_adv && ((m_cnt % F_DIV) == F_LAST);
  assign pulse[1] = m_adv && (m_cnt == M_LAST);
  assign pulse[2] = s_adv && (s_cnt == S_LAST);

  function automatic logic pick(speed_e s, logic [2:0] p);
    case (s)
      SPD_HIGH: pick = p[0];
      SPD_MID:  pick = p[1];
      SPD_LOW:  pick = p[2];
      default:  pick = 1'b0;
    endcase
  endfunction

  assign pulse_new = pick(speed, pulse);
  assign pulse_old = pick(sel_q, pulse);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SPD_MID;
      phi_q <= 1'b0;
    end else begin
      if (sel_q != speed && pulse_new) begin
        sel_q <= speed;
        phi_q <= 1'b1;
      end else begin
        phi_q <= pulse_old;
      end
    end
  end

  assign phi_en = phi_q;

  p_switch_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> phi_q);
  p_low_needs_sub_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_q && sel_q == SPD_LOW) |-> $past(sub_tick));
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int WAIT_W   = 8,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 8,
  parameter int SUB_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_speed,
  input  logic              wr_main_stop,
  input  logic              wr_sub_run,
  input  logic              auto_start,
  input  logic [WAIT_W-1:0] auto_wait,
  input  logic              main_tick,
  input  logic              sub_tick,
  input  logic              main_stable,
  output logic [1:0]        mode,
  output logic              main_en,
  output logic              sub_en,
  output logic              phi_en,
  output logic              err,
  output logic              auto_busy
);
  speed_e speed;
  logic   main_stop, sub_run;

  clk_mode_regs #(.WAIT_W(WAIT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_speed(wr_speed),
    .wr_main_stop(wr_main_stop), .wr_sub_run(wr_sub_run),
    .auto_start(auto_start), .auto_wait(auto_wait), .main_tick(main_tick),
    .main_stable(main_stable), .speed_o(speed), .main_stop_o(main_stop),
    .sub_run_o(sub_run), .err_o(err), .busy_o(auto_busy)
  );

  clk_mode_phi #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .SUB_DIV(SUB_DIV)) phi_i (
    .clk(clk), .rst_n(rst_n), .speed(speed), .main_tick(main_tick),
    .sub_tick(sub_tick), .main_run(!main_stop), .sub_run(sub_run),
    .phi_en(phi_en)
  );

  assign mode    = speed;
  assign main_en = !main_stop;
  assign sub_en  = sub_run;
endmodule

// File: tb/clk_mode_ctrl_tb_top.sv
module clk_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_main_stop = 1'b0, wr_sub_run = 1'b0;
  logic [1:0] wr_speed = 2'b00;
  logic       auto_start = 1'b0, main_stable = 1'b0;
  logic [7:0] auto_wait = 8'd0;
  logic       main_tick = 1'b0, sub_tick = 1'b0;
  logic [1:0] mode;
  logic       main_en, sub_en, phi_en, err, auto_busy;

  int n_run = 0, n_fail = 0, cyc = 0, last_pulse = -1, min_gap = 1000;
  bit gap_en = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  clk_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_speed(wr_speed),
    .wr_main_stop(wr_main_stop), .wr_sub_run(wr_sub_run),
    .auto_start(auto_start), .auto_wait(auto_wait), .main_tick(main_tick),
    .sub_tick(sub_tick), .main_stable(main_stable), .mode(mode),
    .main_en(main_en), .sub_en(sub_en), .phi_en(phi_en), .err(err),
    .auto_busy(auto_busy)
  );

  // main tick every 4 clocks, sub tick every 16
  always_ff @(posedge clk) begin
    cyc       <= cyc + 1;
    main_tick <= ((cyc + 1) % 4) == 0;
    sub_tick  <= ((cyc + 1) % 16) == 3;
  end

  always @(negedge clk) begin
    if (phi_en) begin
      if (gap_en && last_pulse >= 0 && (cyc - last_pulse) < min_gap)
        min_gap = cyc - last_pulse;
      last_pulse = cyc;
    end
  end

  typedef struct packed {
    logic [1:0] spd; logic stp; logic run; logic stb;
    logic [1:0] e_mode; logic e_main; logic e_sub; logic e_err;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{2'b00,1'b0,1'b0,1'b0, 2'b00,1'b1,1'b0,1'b0},
    '{2'b10,1'b0,1'b0,1'b0, 2'b00,1'b1,1'b0,1'b1},
    '{2'b00,1'b0,1'b1,1'b0, 2'b00,1'b1,1'b1,1'b1},
    '{2'b10,1'b0,1'b1,1'b0, 2'b10,1'b1,1'b1,1'b1},
    '{2'b10,1'b1,1'b1,1'b0, 2'b10,1'b0,1'b1,1'b1},
    '{2'b01,1'b1,1'b1,1'b1, 2'b10,1'b0,1'b1,1'b1},
    '{2'b01,1'b0,1'b1,1'b1, 2'b10,1'b0,1'b1,1'b1},
    '{2'b10,1'b0,1'b0,1'b0, 2'b10,1'b0,1'b1,1'b1},
    '{2'b10,1'b0,1'b1,1'b0, 2'b10,1'b1,1'b1,1'b1},
    '{2'b00,1'b0,1'b1,1'b0, 2'b10,1'b1,1'b1,1'b1},
    '{2'b00,1'b0,1'b1,1'b1, 2'b00,1'b1,1'b1,1'b1},
    '{2'b11,1'b0,1'b1,1'b1, 2'b00,1'b1,1'b1,1'b1},
    '{2'b00,1'b1,1'b1,1'b1, 2'b00,1'b1,1'b1,1'b1},
    '{2'b01,1'b0,1'b0,1'b0, 2'b01,1'b1,1'b0,1'b1}
  };
  string vtag [14] = '{"R3","R4 R8","R3","R4","R5","R5","R6","R4",
                       "R5","R6","R6","R7","R5","R3"};

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(logic [1:0] s, logic stp, logic run, logic stb);
    @(negedge clk);
    wr_en = 1'b1; wr_speed = s; wr_main_stop = stp; wr_sub_run = run; main_stable = stb;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_auto(logic [7:0] w);
    @(negedge clk);
    auto_start = 1'b1; auto_wait = w;
    @(negedge clk);
    auto_start = 1'b0;
  endtask

  task automatic count_phi(int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (phi_en) cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    do_reset();
    @(negedge clk);
    // R1 reset state packed as {mode,main_en,sub_en,err,busy}
    check("R1 reset state", {mode, main_en, sub_en, err, auto_busy}, 6'b01_1_0_0_0);

    for (int i = 0; i < 14; i++) begin
      do_write(VEC[i].spd, VEC[i].stp, VEC[i].run, VEC[i].stb);
      check($sformatf("%s vector %0d", vtag[i], i),
            {mode, main_en, sub_en, err},
            {VEC[i].e_mode, VEC[i].e_main, VEC[i].e_sub, VEC[i].e_err});
    end

    // R2 strobe rates
    do_reset();
    repeat (64) @(negedge clk);
    count_phi(256, c);
    check("R2 middle rate", c, 8);
    do_write(2'b00, 1'b0, 1'b0, 1'b1);
    gap_en = 1'b1; min_gap = 1000; last_pulse = -1;
    repeat (64) @(negedge clk);
    count_phi(256, c);
    check("R2 high rate", c, 32);
    // R10 spacing across high/middle changes
    do_write(2'b01, 1'b0, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    do_write(2'b00, 1'b0, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    gap_en = 1'b0;
    check("R10 min strobe gap ok", (min_gap >= 8) ? 1 : 0, 1);
    do_write(2'b00, 1'b0, 1'b1, 1'b1);
    do_write(2'b10, 1'b0, 1'b1, 1'b1);
    repeat (100) @(negedge clk);
    count_phi(512, c);
    check("R2 low rate", c, 16);

    // R9 refused start with main stopped
    do_write(2'b10, 1'b1, 1'b1, 1'b1);
    pulse_auto(8'd5);
    repeat (20) @(negedge clk);
    check("R9 refused start", {mode, err, auto_busy}, 4'b10_1_0);

    // R9 timed switch from high speed
    do_reset();
    do_write(2'b00, 1'b0, 1'b0, 1'b1);
    pulse_auto(8'd5);
    repeat (8) @(negedge clk);
    check("R9 waiting", {mode, auto_busy, err}, 4'b00_1_0);
    do_write(2'b01, 1'b0, 1'b0, 1'b1);
    check("R9 write during wait refused", {mode, err}, 3'b00_1);
    repeat (40) @(negedge clk);
    check("R9 switched to middle", {mode, auto_busy}, 3'b01_0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule